// File: doc/BRIEF.md
# Triple Display Frame Buffer Manager

This block manages four equally sized frame regions in a shared external memory. Region 0 is the render region, where a drawing engine builds the next picture. Regions 1, 2 and 3 are display regions that hold finished frames. When the renderer asks for a flush, the block starts an external copy engine. The copy engine moves the render region into a display region that is neither on screen nor queued for the screen. When the copy reports completion, that region becomes the newest complete frame.

The display fetch logic reads from the base address this block presents. That address moves to the newest complete frame only when a vertical sync pulse arrives, so a frame is never switched part way through a scan. The copy path and the scan-out path use separate memory ports and run at the same time. Rendering is therefore never stalled waiting for vsync, and the display never tears.

The memory controller and the pixel copy datapath lie outside this block.

Top module: `frame_rotator`

## Requirements
- R1: While reset is held and directly after it, `dispBase` equals the base of region 1, `copyStart` is 0 and `copySrcBase` equals the base of region 0.
- R2: The base of region i (0 = render, 1..3 = display) is `MEM_BASE + i*FRAME_BYTES`. `copySrcBase` always carries the region 0 base. `dispBase` never carries it.
- R3: A `flushReq` sampled while no copy is in flight produces a one-cycle `copyStart` pulse in the following cycle.
- R4: The destination of a copy is the lowest-numbered display region that is neither the region on screen nor the newest complete region. The first flush after reset therefore targets region 2. While a copy is in flight, `copyDstBase` differs from `dispBase`.
- R5: `dispBase` changes only in the cycle after a sampled `vsyncPulse`. It then takes the base of the newest complete region.
- R6: A `flushReq` sampled while a copy is in flight is held. It is launched with a `copyStart` two cycles after the `copyDone` that ends the copy. Several held requests merge into one copy, and only one copy is ever outstanding.
- R7: A `copyDone` sampled while no copy is in flight is ignored. It changes neither `copyStart` nor the region shown at later vsyncs.
- R8: When `vsyncPulse` and `copyDone` fall in the same cycle, the vsync latches the previously newest region. The just-completed region is shown at the next vsync.
- R9: A vsync before any copy has completed keeps `dispBase` on region 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushReq | input | 1 | One-cycle request to commit the render region |
| vsyncPulse | input | 1 | One-cycle vertical sync pulse from video timing |
| copyDone | input | 1 | Copy engine finished the current copy |
| copyStart | output | 1 | One-cycle start pulse to the copy engine |
| copySrcBase | output | ADDR_W | Source base address for the copy (render region) |
| copyDstBase | output | ADDR_W | Destination base address for the copy |
| dispBase | output | ADDR_W | Base address the display fetch logic scans |

## Verification
Two collisions carry the risk: a vsync landing in the same cycle as a copy completion, and a flush request landing while a copy is in flight or as it completes. Both are driven on purpose in a directed sequence. They also occur freely under random flush, vsync and copy latency, together with stray completions while idle. A cycle-level reference model of region indices, the pending request and the busy flag predicts every `copyStart`, destination and display base. Each cycle is judged against that model, and the checker also confirms that the copy target never equals the scanned region.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int NUM_REGIONS = 4;
  localparam int IDX_W = $clog2(NUM_REGIONS);

  typedef logic [IDX_W-1:0] regionIdx_t;

  typedef struct packed {
    logic launch;
    logic finish;
    logic latch;
  } strobes_t;
endpackage

// File: rtl/fr_ctrl.sv
module fr_ctrl
  import fr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     flushReq,
  input  logic     copyDone,
  input  logic     vsyncPulse,
  output strobes_t strobes,
  output logic     copyStart
);
  logic busy;
  logic pending;

  always_comb begin
    strobes.launch = !busy && (pending || flushReq);
    strobes.finish = busy && copyDone;
    strobes.latch  = vsyncPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      pending   <= 1'b0;
      copyStart <= 1'b0;
    end else begin
      copyStart <= strobes.launch;
      busy      <= strobes.launch || (busy && !copyDone);
      pending   <= busy && (pending || flushReq);
    end
  end
endmodule

// File: rtl/fr_regions.sv
module fr_regions
  import fr_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE    = '0,
  parameter int unsigned       FRAME_BYTES = 32'd3145728
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  output logic [ADDR_W-1:0] copySrcBase,
  output logic [ADDR_W-1:0] copyDstBase,
  output logic [ADDR_W-1:0] dispBase
);
  logic [ADDR_W-1:0] baseTab [NUM_REGIONS];
  regionIdx_t scanIdx;
  regionIdx_t newestIdx;
  regionIdx_t dstIdx;
  regionIdx_t pickIdx;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_base
    assign baseTab[g] = MEM_BASE + ADDR_W'(g * FRAME_BYTES);
  end

  // lowest display region that is neither scanned nor queued
  always_comb begin
    pickIdx = regionIdx_t'(1);
    for (int i = NUM_REGIONS - 1; i >= 1; i--) begin
      if (regionIdx_t'(i) != scanIdx && regionIdx_t'(i) != newestIdx)
        pickIdx = regionIdx_t'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanIdx   <= regionIdx_t'(1);
      newestIdx <= regionIdx_t'(1);
      dstIdx    <= regionIdx_t'(2);
    end else begin
      if (strobes.launch) dstIdx    <= pickIdx;
      if (strobes.latch)  scanIdx   <= newestIdx;
      if (strobes.finish) newestIdx <= dstIdx;
    end
  end

  assign copySrcBase = baseTab[0];
  assign copyDstBase = baseTab[dstIdx];
  assign dispBase    = baseTab[scanIdx];
endmodule

// File: rtl/frame_rotator.sv
module frame_rotator #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE    = '0,
  parameter int unsigned       FRAME_BYTES = 32'd3145728
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushReq,
  input  logic              vsyncPulse,
  input  logic              copyDone,
  output logic              copyStart,
  output logic [ADDR_W-1:0] copySrcBase,
  output logic [ADDR_W-1:0] copyDstBase,
  output logic [ADDR_W-1:0] dispBase
);
  fr_pkg::strobes_t strobes;

  fr_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flushReq   (flushReq),
    .copyDone   (copyDone),
    .vsyncPulse (vsyncPulse),
    .strobes    (strobes),
    .copyStart  (copyStart)
  );

  fr_regions #(
    .ADDR_W      (ADDR_W),
    .MEM_BASE    (MEM_BASE),
    .FRAME_BYTES (FRAME_BYTES)
  ) i_regions (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .copySrcBase (copySrcBase),
    .copyDstBase (copyDstBase),
    .dispBase    (dispBase)
  );
endmodule

// File: rtl/frame_rotator_checker.sv
module frame_rotator_checker #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              vsyncPulse,
  input logic              copyDone,
  input logic              copyStart,
  input logic [ADDR_W-1:0] copySrcBase,
  input logic [ADDR_W-1:0] copyDstBase,
  input logic [ADDR_W-1:0] dispBase
);
  logic inFlight;

  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= 1'b0;
    else       inFlight <= (inFlight || copyStart) && !copyDone;
  end

  p_src_render_r2: assert property (@(posedge clk) disable iff (!rstN)
    copyStart |-> copySrcBase == MEM_BASE);

  p_disp_not_render_r2: assert property (@(posedge clk) disable iff (!rstN)
    dispBase != MEM_BASE);

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    copyStart |=> !copyStart);

  p_dst_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (copyStart || inFlight) |-> copyDstBase != dispBase);

  p_disp_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncPulse |=> $stable(dispBase));

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !copyStart);
endmodule

bind frame_rotator frame_rotator_checker #(
  .ADDR_W   (ADDR_W),
  .MEM_BASE (MEM_BASE)
) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .vsyncPulse  (vsyncPulse),
  .copyDone    (copyDone),
  .copyStart   (copyStart),
  .copySrcBase (copySrcBase),
  .copyDstBase (copyDstBase),
  .dispBase    (dispBase)
);

// File: tb/test_frame_rotator.sv
module test_frame_rotator;
  localparam int          ADDR_W = 32;
  localparam logic [31:0] MBASE  = 32'h1000_0000;
  localparam int unsigned FRAME  = 32'd3145728;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flushReq = 1'b0, vsyncPulse = 1'b0, copyDone = 1'b0;
  logic copyStart;
  logic [ADDR_W-1:0] copySrcBase, copyDstBase, dispBase;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // reference model state
  int  mScan = 1, mNewest = 1, mDst = 2;
  bit  mBusy = 0, mPend = 0, mStart = 0;
  int  engCount = 0;
  bit  engAuto = 0;

  always #2.5 clk = ~clk;

  frame_rotator #(.ADDR_W(ADDR_W), .MEM_BASE(MBASE), .FRAME_BYTES(FRAME)) i_frame_rotator (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .vsyncPulse(vsyncPulse),
    .copyDone(copyDone), .copyStart(copyStart), .copySrcBase(copySrcBase),
    .copyDstBase(copyDstBase), .dispBase(dispBase)
  );

  function automatic logic [31:0] baseOf(int idx);
    return MBASE + 32'(idx) * FRAME;
  endfunction

  function automatic int pickFree(int scan, int newest);
    for (int i = 1; i <= 3; i++)
      if (i != scan && i != newest) return i;
    return 1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // one cycle: drive, advance model, compare after the edge
  task automatic tick(bit f, bit v, bit d);
    bit launch, finish;
    int pick, oldNewest, oldDst;
    flushReq = f; vsyncPulse = v; copyDone = d;
    launch = !mBusy && (mPend || f);
    finish = mBusy && d;
    pick = pickFree(mScan, mNewest);
    oldNewest = mNewest; oldDst = mDst;
    @(posedge clk);
    #1;
    mStart = launch;
    mPend  = mBusy && (mPend || f);
    mBusy  = launch || (mBusy && !d);
    if (launch) mDst = pick;
    if (v) mScan = oldNewest;
    if (finish) mNewest = oldDst;
    check("R3 copyStart", 32'(copyStart), 32'(mStart));
    if (mStart) check("R4 copyDstBase", copyDstBase, baseOf(mDst));
    check("R5 dispBase", dispBase, baseOf(mScan));
    check("R2 copySrcBase", copySrcBase, baseOf(0));
    if (engAuto && copyStart) engCount = 1 + int'($urandom % 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 dispBase in reset", dispBase, baseOf(1));
    check("R1 copyStart in reset", 32'(copyStart), 32'd0);
    check("R1 copySrcBase in reset", copySrcBase, baseOf(0));
    rstN = 1'b1;
    tick(0, 0, 0);
    check("R1 dispBase after reset", dispBase, baseOf(1));

    // directed corner cases
    tick(0, 1, 0);
    check("R9 vsync before any copy", dispBase, baseOf(1));
    tick(1, 0, 0);
    check("R3 start after flush", 32'(copyStart), 32'd1);
    check("R4 first target region 2", copyDstBase, baseOf(2));
    tick(1, 0, 0);
    check("R6 start not repeated in flight", 32'(copyStart), 32'd0);
    tick(1, 1, 0);
    check("R5 vsync with nothing new", dispBase, baseOf(1));
    tick(0, 0, 1);
    check("R6 no start on done cycle", 32'(copyStart), 32'd0);
    tick(0, 0, 0);
    check("R6 held flush launched", 32'(copyStart), 32'd1);
    check("R4 second target region 3", copyDstBase, baseOf(3));
    tick(0, 0, 0);
    check("R6 merged flushes one copy", 32'(copyStart), 32'd0);
    tick(0, 1, 1);
    check("R8 vsync with done shows prior", dispBase, baseOf(2));
    tick(0, 0, 0);
    check("R8 held until next vsync", dispBase, baseOf(2));
    tick(0, 0, 1);
    check("R7 stray done no start", 32'(copyStart), 32'd0);
    tick(0, 1, 0);
    check("R7 stray done left newest", dispBase, baseOf(3));
    tick(1, 0, 0);
    check("R4 target avoids scan and newest", copyDstBase, baseOf(1));

    // random phase with a modelled copy engine
    engAuto = 1;
    engCount = 3;
    for (int n = 0; n < 4000; n++) begin
      bit f, v, d;
      f = ($urandom % 6) == 0;
      v = ($urandom % 9) == 0;
      d = 1'b0;
      if (engCount > 0) begin
        engCount--;
        if (engCount == 0) d = 1'b1;
      end else if (!mBusy && ($urandom % 8) == 0) begin
        d = 1'b1;
      end
      tick(f, v, d);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule